// File: doc/BRIEF.md
# Signed Power-of-Two Divider Using Shifts

This unit computes the quotient of a signed two's-complement operand divided by 2^k, where k is a small constant-like shift count. The quotient is truncated toward zero, which is the rule C integer division follows. A plain arithmetic right shift does not meet that rule: it rounds negative operands toward minus infinity. The unit fixes this with a bias that it adds before the shift. The bias is built only from shifts and an adder, so the data path contains no divider.

The quotient is available combinationally in the same cycle as its operands. A thin registered stage captures the quotient on any cycle with `in_vld` high, so a synchronous consumer can take it at the next clock edge. A shift count of 31 or more is outside the legal range, and the unit gives no particular result for it.

Top module: `pow2_sdiv`

## Requirements
- R1: For every shift count k from 0 to 30 and every 32-bit signed dividend x, `quo_comb` equals x / 2^k truncated toward zero.
- R2: When k is 0, `quo_comb` equals the dividend bit for bit.
- R3: For a dividend whose bit 31 is 0, `quo_comb` equals the dividend logically shifted right by k.
- R4: For a negative dividend with nonzero bits below position k, `quo_comb` is one greater than the arithmetic right shift by k. This means -1 with k of 1 or more gives 0.
- R5: A dividend of -2^31 with k from 1 to 30 gives exactly -2^(31-k), with no overflow in the biased sum.
- R6: `quo_comb` settles in the same cycle as `dividend` and `shamt`, with no clock edge in between.
- R7: When `in_vld` is high at a rising edge, `quo` takes the value `quo_comb` had at that edge and `out_vld` goes high after the edge.
- R8: When `in_vld` is low at a rising edge, `quo` keeps its value and `out_vld` goes low.
- R9: While `rst_n` is low, `quo` and `out_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands are valid; capture the quotient at this edge |
| dividend | input | 32 | Signed dividend x |
| shamt | input | 5 | Shift count k, legal range 0 to 30 |
| quo_comb | output | 32 | Combinational signed quotient |
| out_vld | output | 1 | Registered quotient is fresh |
| quo | output | 32 | Registered signed quotient |

## Verification
The assertions check these properties on every clock cycle:
- a zero shift count passes the dividend through unchanged;
- a non-negative dividend gives the plain logical shift;
- a negative dividend gives a result that lies between the floor result and one above it;
- the quotient never takes the opposite sign of the dividend;
- the capture and hold rules of the output register are kept.

The assertions do not prove exact truncation toward zero. That is shown by the bench scenarios, which compare every legal shift count against a wide-integer quotient. The stimulus includes the extreme dividends, -1, and random operands, and it also covers holding the registered output while `in_vld` is low.

// File: rtl/pow2_sdiv_pkg.sv
package pow2_sdiv_pkg;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned SH_W_DEF   = 5;
endpackage

// File: rtl/sdiv_bias_gen.sv
module sdiv_bias_gen #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] bias
);
    localparam int unsigned RS_W = SH_W + 1;
    localparam logic [RS_W-1:0] WIDTH_L = RS_W'(DATA_W);

    logic [DATA_W-1:0] sign_word;
    logic [RS_W-1:0]   rshift;

    always_comb begin
        // Negative operand: low k bits set (2^k - 1); otherwise zero.
        sign_word = {DATA_W{opnd[DATA_W-1]}};
        rshift    = WIDTH_L - {1'b0, shamt};
        if (shamt == '0) begin
            bias = '0;
        end else begin
            bias = sign_word >> rshift;
        end
    end
endmodule

// File: rtl/sdiv_shift_core.sv
module sdiv_shift_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SH_W   = 5
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] bias,
    output logic [DATA_W-1:0] result
);
    logic signed [DATA_W-1:0] biased;

    always_comb begin
        // Negative plus a bias below 2^31 cannot overflow.
        biased = $signed(opnd + bias);
        result = DATA_W'(biased >>> shamt);
    end
endmodule

// File: rtl/pow2_sdiv.sv
module pow2_sdiv
    import pow2_sdiv_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned SH_W   = SH_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] dividend,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] quo_comb,
    output logic              out_vld,
    output logic [DATA_W-1:0] quo
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] quo;
    } out_st_t;

    logic [DATA_W-1:0] bias;
    out_st_t           st_d, st_q;

    sdiv_bias_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) i_bias (
        .opnd  (dividend),
        .shamt (shamt),
        .bias  (bias)
    );

    sdiv_shift_core #(.DATA_W(DATA_W), .SH_W(SH_W)) i_core (
        .opnd   (dividend),
        .shamt  (shamt),
        .bias   (bias),
        .result (quo_comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.quo = quo_comb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign quo     = st_q.quo;

    AST_ZERO_SHIFT_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (shamt == '0) |-> (quo_comb == dividend)); // R2
    AST_NONNEG_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
        !dividend[DATA_W-1] |-> (quo_comb == (dividend >> shamt))); // R3
    AST_NEG_ROUND_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dividend[DATA_W-1] |->
            ((quo_comb == DATA_W'($signed(dividend) >>> shamt)) ||
             (quo_comb == DATA_W'(($signed(dividend) >>> shamt) + 1)))); // R4
    AST_SIGN_NEVER_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (quo_comb != '0) |-> (quo_comb[DATA_W-1] == dividend[DATA_W-1])); // R1
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_vld && quo == $past(quo_comb))); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(quo))); // R8
endmodule

// File: tb/test_pow2_sdiv.sv
module test_pow2_sdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] dividend = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] quo_comb, quo;
    logic        out_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pow2_sdiv i_pow2_sdiv (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .dividend(dividend), .shamt(shamt),
        .quo_comb(quo_comb), .out_vld(out_vld), .quo(quo)
    );

    function automatic logic [31:0] ref_quot(input logic [31:0] x, input int k);
        longint xv, dv;
        xv = longint'($signed(x));
        dv = longint'(1) << k;
        return 32'(xv / dv);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [31:0] x, input int k);
        if (k == 0) return "R2 R6";
        if (x == 32'h8000_0000) return "R5 R6";
        if (x[31] == 1'b1) return "R4 R6";
        return "R3 R6";
    endfunction

    task automatic apply(input logic [31:0] x, input int k);
        logic [31:0] e;
        e = ref_quot(x, k);
        @(negedge clk);
        dividend = x; shamt = 5'(k); in_vld = 1'b1;
        #1;
        chk(tag_for(x, k), quo_comb, e);
        @(posedge clk); #1;
        chk("R7 quo", quo, e);
        chk("R7 out_vld", {31'd0, out_vld}, 32'd1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R9 quo", quo, 32'd0);
        chk("R9 out_vld", {31'd0, out_vld}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        for (int k = 0; k < 31; k++) begin
            apply(32'd0, k);
            apply(32'hFFFF_FFFF, k);
            apply(32'd1, k);
            apply(32'h8000_0000, k);
            apply(32'h7FFF_FFFF, k);
            apply(-(32'd1 << k) - 32'd1, k);
            for (int r = 0; r < 6; r++) begin
                apply($urandom(), k);
            end
        end

        // R5 spot check with an explicit value: -2^31 / 2^4 = -2^27
        apply(32'h8000_0000, 4);
        chk("R5 explicit", quo, 32'hF800_0000);
        // R4 explicit: -1 / 2 rounds toward zero
        apply(32'hFFFF_FFFF, 1);
        chk("R4 explicit", quo, 32'd0);
        // R1 explicit: -7 / 4 = -1
        apply(32'hFFFF_FFF9, 2);
        chk("R1 explicit", quo, 32'hFFFF_FFFF);

        // R8: in_vld low, operands change, registered output holds
        held = quo;
        @(negedge clk);
        in_vld = 1'b0; dividend = 32'h1234_5678; shamt = 5'd3;
        @(posedge clk); #1;
        chk("R8 quo hold", quo, held);
        chk("R8 out_vld low", {31'd0, out_vld}, 32'd0);
        chk("R6 comb while idle", quo_comb, 32'h0246_8ACF);

        // R9: reset clears the register
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R9 quo after reset", quo, 32'd0);
        finish_run();
    end
endmodule